// File: doc/BRIEF.md
# Dual-Channel Converter Calibration Sequencer

This block runs the internal offset and gain matching calibration of a two-channel converter. A neighbouring serial interface hands it each control word as it finishes loading. When the word goes to control address 0 with its start bit set, the sequencer latches two clock-rate bits and the channel configuration. It then walks through a fixed series of timed phases counted on the master clock. For the whole run it holds a busy flag high, holds both converter channels out of normal acquisition, and raises exactly one phase strobe. The strobe tells the offset engine of channel I, the offset engine of channel Q or the gain-matching engine that its turn has come.

The two rate bits set the offset phase length to one of four values, so a slower converter clock gets a shorter run in cycles. In dual-channel operation the order is fixed: channel I offset, then channel Q offset, then a gain phase of fixed length. When only one channel is in use, only that channel's offset phase runs, and the gain phase is left out. A one-cycle done pulse marks the end of a run. The clock of the second channel plays no part here.

Top module: `adc_cal_sequencer`

## Requirements
- R1: After a synchronous reset, `cal_busy`, both channel disables, all three phase strobes and `cal_done` are low.
- R2: A run starts only on a cycle with `cfg_load` high, `cfg_addr` equal to 0 and bit 12 of `cfg_word` set while idle; `cal_busy` is high from the next cycle. Loads to any other address, or with bit 12 clear, have no effect.
- R3: The rate bits are a = `cfg_word[14]` and b = `cfg_word[13]`. In dual mode `cal_busy` stays high for 10112, 6016, 3968 or 2944 cycles for {a,b} = 11, 10, 01, 00.
- R4: `chan_i_off` and `chan_q_off` are both high exactly while `cal_busy` is high.
- R5: In dual mode the phases run in this order: `ofs_run_i` for N cycles, then `ofs_run_q` for N cycles, then `gain_run` for 1024 cycles. N is 4544, 2496, 1472 or 960 for {a,b} = 11, 10, 01, 00. While busy exactly one strobe is high, and while idle none is.
- R6: With `single_mode` = 1, only the offset strobe of the channel picked by `sel_q` (0 = I, 1 = Q) runs, for N cycles. `cal_busy` falls on the cycle after it, and `gain_run` never rises.
- R7: Rate bits, `single_mode` and `sel_q` are captured at the start. A later load, including one with the start bit set, does not change the run in progress.
- R8: `cal_done` is high for exactly one cycle: the first cycle after `cal_busy` falls at the end of a run.
- R9: Asserting `rst` during a run returns the block to the state of R1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master (channel I) clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | One-cycle strobe: a serial control word has finished loading |
| cfg_addr | input | 3 | Control register address of the loaded word |
| cfg_word | input | 16 | Loaded control word (bit 12 start, bit 14 rate a, bit 13 rate b) |
| single_mode | input | 1 | 1 = only one channel in use |
| sel_q | input | 1 | Channel used in single mode: 0 = I, 1 = Q |
| cal_busy | output | 1 | High for the whole calibration run |
| chan_i_off | output | 1 | Channel I removed from acquisition |
| chan_q_off | output | 1 | Channel Q removed from acquisition |
| ofs_run_i | output | 1 | Offset phase of channel I is active |
| ofs_run_q | output | 1 | Offset phase of channel Q is active |
| gain_run | output | 1 | Inter-channel gain phase is active |
| cal_done | output | 1 | One-cycle pulse after a run completes |

## Verification
The properties assume that `cfg_load` is a clean one-cycle strobe, sampled on the master clock, with `cfg_addr` and `cfg_word` valid in that same cycle. They also assume that reset is held for at least one edge. The fall-to-done check excludes the cycle after a reset, because a reset drops the busy flag without any completion. The stimulus drives every input on the falling edge, pulses `cfg_load` for one cycle per write, and changes `single_mode` and `sel_q` during runs only to show that the values captured at the start still govern.

// File: rtl/calseq_pkg.sv
package calseq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_OFS_I = 2'd1,
        PH_OFS_Q = 2'd2,
        PH_GAIN  = 2'd3
    } cal_phase_e;

    typedef struct packed {
        logic rate_a;
        logic rate_b;
        logic single;
        logic use_q;
    } cal_cfg_t;

    localparam int unsigned GAIN_CYC_DEF = 1024;
    localparam int unsigned OFS_11_DEF   = 4544;
    localparam int unsigned OFS_10_DEF   = 2496;
    localparam int unsigned OFS_01_DEF   = 1472;
    localparam int unsigned OFS_00_DEF   = 960;

    function automatic int unsigned max2(input int unsigned x, input int unsigned y);
        return (x > y) ? x : y;
    endfunction

    function automatic logic [1:0] rate_of(input cal_cfg_t c);
        return {c.rate_a, c.rate_b};
    endfunction

endpackage

// File: rtl/calseq_len_sel.sv
module calseq_len_sel #(
    parameter int unsigned CNT_W  = 13,
    parameter int unsigned OFS_11 = 4544,
    parameter int unsigned OFS_10 = 2496,
    parameter int unsigned OFS_01 = 1472,
    parameter int unsigned OFS_00 = 960
) (
    input  logic [1:0]       rate,
    output logic [CNT_W-1:0] ofs_len
);
    localparam int unsigned NSET = 4;

    logic [CNT_W-1:0] len_tab [NSET];

    for (genvar g = 0; g < NSET; g++) begin : g_tab
        localparam int unsigned VAL = (g == 3) ? OFS_11 :
                                      (g == 2) ? OFS_10 :
                                      (g == 1) ? OFS_01 : OFS_00;
        assign len_tab[g] = CNT_W'(VAL);
    end

    assign ofs_len = len_tab[rate];
endmodule

// File: rtl/calseq_timer.sv
module calseq_timer #(
    parameter int unsigned CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expire = (cnt == '0);
endmodule

// File: rtl/calseq_fsm.sv
module calseq_fsm
    import calseq_pkg::*;
#(
    parameter int unsigned CNT_W    = 13,
    parameter int unsigned GAIN_CYC = 1024
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_req,
    input  cal_cfg_t         cfg_in,
    input  logic [CNT_W-1:0] ofs_len,
    input  logic             tmr_expire,
    output logic [1:0]       rate_sel,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output cal_phase_e       phase,
    output logic             done
);
    cal_phase_e phase_nx;
    cal_cfg_t   cfg_q;
    logic       finish;

    assign rate_sel = (phase == PH_IDLE) ? rate_of(cfg_in) : rate_of(cfg_q);

    always_comb begin
        phase_nx = phase;
        tmr_load = 1'b0;
        tmr_val  = '0;
        finish   = 1'b0;
        unique case (phase)
            PH_IDLE: begin
                if (start_req) begin
                    tmr_load = 1'b1;
                    tmr_val  = ofs_len - 1'b1;
                    phase_nx = (cfg_in.single && cfg_in.use_q) ? PH_OFS_Q : PH_OFS_I;
                end
            end
            PH_OFS_I: begin
                if (tmr_expire) begin
                    if (cfg_q.single) begin
                        phase_nx = PH_IDLE;
                        finish   = 1'b1;
                    end else begin
                        tmr_load = 1'b1;
                        tmr_val  = ofs_len - 1'b1;
                        phase_nx = PH_OFS_Q;
                    end
                end
            end
            PH_OFS_Q: begin
                if (tmr_expire) begin
                    if (cfg_q.single) begin
                        phase_nx = PH_IDLE;
                        finish   = 1'b1;
                    end else begin
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(GAIN_CYC - 1);
                        phase_nx = PH_GAIN;
                    end
                end
            end
            PH_GAIN: begin
                if (tmr_expire) begin
                    phase_nx = PH_IDLE;
                    finish   = 1'b1;
                end
            end
            default: phase_nx = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cfg_q <= '0;
            done  <= 1'b0;
        end else begin
            phase <= phase_nx;
            done  <= finish;
            if (phase == PH_IDLE && start_req) begin
                cfg_q <= cfg_in;
            end
        end
    end
endmodule

// File: rtl/adc_cal_sequencer.sv
module adc_cal_sequencer
    import calseq_pkg::*;
#(
    parameter int unsigned WORD_W    = 16,
    parameter int unsigned ADDR_W    = 3,
    parameter int unsigned CTRL_ADDR = 0,
    parameter int unsigned START_BIT = 12,
    parameter int unsigned RATE_B_BIT = 13,
    parameter int unsigned RATE_A_BIT = 14,
    parameter int unsigned GAIN_CYC  = GAIN_CYC_DEF,
    parameter int unsigned OFS_11    = OFS_11_DEF,
    parameter int unsigned OFS_10    = OFS_10_DEF,
    parameter int unsigned OFS_01    = OFS_01_DEF,
    parameter int unsigned OFS_00    = OFS_00_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_load,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [WORD_W-1:0] cfg_word,
    input  logic              single_mode,
    input  logic              sel_q,
    output logic              cal_busy,
    output logic              chan_i_off,
    output logic              chan_q_off,
    output logic              ofs_run_i,
    output logic              ofs_run_q,
    output logic              gain_run,
    output logic              cal_done
);
    localparam int unsigned MAX_LEN = max2(max2(max2(OFS_11, OFS_10), max2(OFS_01, OFS_00)), GAIN_CYC);
    localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

    cal_cfg_t         cfg_in;
    logic             start_req;
    logic [1:0]       rate_sel;
    logic [CNT_W-1:0] ofs_len;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expire;
    cal_phase_e       phase;

    assign start_req = cfg_load && (cfg_addr == ADDR_W'(CTRL_ADDR)) && cfg_word[START_BIT];

    always_comb begin
        cfg_in.rate_a = cfg_word[RATE_A_BIT];
        cfg_in.rate_b = cfg_word[RATE_B_BIT];
        cfg_in.single = single_mode;
        cfg_in.use_q  = sel_q;
    end

    calseq_len_sel #(
        .CNT_W (CNT_W),
        .OFS_11(OFS_11),
        .OFS_10(OFS_10),
        .OFS_01(OFS_01),
        .OFS_00(OFS_00)
    ) u_len (
        .rate   (rate_sel),
        .ofs_len(ofs_len)
    );

    calseq_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expire  (tmr_expire)
    );

    calseq_fsm #(.CNT_W(CNT_W), .GAIN_CYC(GAIN_CYC)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start_req (start_req),
        .cfg_in    (cfg_in),
        .ofs_len   (ofs_len),
        .tmr_expire(tmr_expire),
        .rate_sel  (rate_sel),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .phase     (phase),
        .done      (cal_done)
    );

    assign cal_busy   = (phase != PH_IDLE);
    assign chan_i_off = cal_busy;
    assign chan_q_off = cal_busy;
    assign ofs_run_i  = (phase == PH_OFS_I);
    assign ofs_run_q  = (phase == PH_OFS_Q);
    assign gain_run   = (phase == PH_GAIN);
endmodule

// File: rtl/calseq_checker.sv
module calseq_checker #(
    parameter int unsigned ADDR_W    = 3,
    parameter int unsigned WORD_W    = 16,
    parameter int unsigned START_BIT = 12,
    parameter int unsigned GAIN_CYC  = 1024
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_load,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [WORD_W-1:0] cfg_word,
    input logic              cal_busy,
    input logic              chan_i_off,
    input logic              chan_q_off,
    input logic              ofs_run_i,
    input logic              ofs_run_q,
    input logic              gain_run,
    input logic              cal_done
);
    logic        go;
    logic [15:0] gain_cnt;

    assign go = cfg_load && (cfg_addr == '0) && cfg_word[START_BIT];

    always_ff @(posedge clk) begin
        if (rst || !gain_run) gain_cnt <= '0;
        else                  gain_cnt <= gain_cnt + 1'b1;
    end

    p_start_r2: assert property (@(posedge clk) disable iff (rst)
        (!cal_busy && go) |=> cal_busy);

    p_no_start_r2: assert property (@(posedge clk) disable iff (rst)
        (!cal_busy && !go) |=> !cal_busy);

    p_chan_off_r4: assert property (@(posedge clk) disable iff (rst)
        (chan_i_off == cal_busy) && (chan_q_off == cal_busy));

    p_one_phase_r5: assert property (@(posedge clk) disable iff (rst)
        cal_busy |-> ($countones({ofs_run_i, ofs_run_q, gain_run}) == 1));

    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        !cal_busy |-> ($countones({ofs_run_i, ofs_run_q, gain_run}) == 0));

    p_gain_after_q_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(gain_run) |-> $past(ofs_run_q));

    p_gain_len_r5: assert property (@(posedge clk) disable iff (rst)
        ($fell(gain_run) && !$past(rst)) |-> (gain_cnt == 16'(GAIN_CYC)));

    p_done_after_busy_r8: assert property (@(posedge clk) disable iff (rst)
        cal_done |-> (!cal_busy && $past(cal_busy)));

    p_fall_gives_done_r8: assert property (@(posedge clk) disable iff (rst)
        ($fell(cal_busy) && !$past(rst)) |-> cal_done);

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        cal_done |=> !cal_done);
endmodule

bind adc_cal_sequencer calseq_checker #(
    .ADDR_W   (ADDR_W),
    .WORD_W   (WORD_W),
    .START_BIT(START_BIT),
    .GAIN_CYC (GAIN_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_load  (cfg_load),
    .cfg_addr  (cfg_addr),
    .cfg_word  (cfg_word),
    .cal_busy  (cal_busy),
    .chan_i_off(chan_i_off),
    .chan_q_off(chan_q_off),
    .ofs_run_i (ofs_run_i),
    .ofs_run_q (ofs_run_q),
    .gain_run  (gain_run),
    .cal_done  (cal_done)
);

// File: tb/adc_cal_sequencer_test.sv
module adc_cal_sequencer_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_load = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_word = '0;
    logic        single_mode = 1'b0;
    logic        sel_q = 1'b0;
    logic cal_busy, chan_i_off, chan_q_off, ofs_run_i, ofs_run_q, gain_run, cal_done;

    int n_checks = 0;
    int n_fail   = 0;

    // reference model state
    int m_busy = 0, m_phase = 0, m_rem = 0, m_done = 0, m_n = 0, m_dual = 0;
    // run length monitor
    int run_len = 0, exp_total = 0, prev_busy = 0, skip_len = 0, cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_cal_sequencer uut (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_addr(cfg_addr),
        .cfg_word(cfg_word), .single_mode(single_mode), .sel_q(sel_q),
        .cal_busy(cal_busy), .chan_i_off(chan_i_off), .chan_q_off(chan_q_off),
        .ofs_run_i(ofs_run_i), .ofs_run_q(ofs_run_q), .gain_run(gain_run),
        .cal_done(cal_done)
    );

    function automatic int tcal(input int a, input int b);
        if (a == 1 && b == 1) return 10112;
        if (a == 1)           return 6016;
        if (b == 1)           return 3968;
        return 2944;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_phase = 0; m_rem = 0; m_done = 0;
        end else begin
            m_done = 0;
            if (m_busy == 1) begin
                m_rem--;
                if (m_rem == 0) begin
                    if (m_dual == 1 && m_phase == 1) begin
                        m_phase = 2; m_rem = m_n;
                    end else if (m_dual == 1 && m_phase == 2) begin
                        m_phase = 3; m_rem = 1024;
                    end else begin
                        m_busy = 0; m_phase = 0; m_done = 1;
                    end
                end
            end else if (cfg_load && cfg_addr == 3'd0 && cfg_word[12]) begin
                m_busy = 1;
                m_n    = (tcal(cfg_word[14], cfg_word[13]) - 1024) / 2;
                m_dual = single_mode ? 0 : 1;
                m_phase = (single_mode && sel_q) ? 2 : 1;
                m_rem  = m_n;
            end
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            chk(1'b0, "watchdog", cycles, WATCHDOG);
            finish_run();
        end
        if (!rst) begin
            chk(cal_busy == m_busy[0], "R3 busy", cal_busy, m_busy);
            chk(chan_i_off == m_busy[0] && chan_q_off == m_busy[0], "R4 chan_off",
                {chan_i_off, chan_q_off}, m_busy * 3);
            chk(ofs_run_i == (m_phase == 1), "R5 ofs_run_i", ofs_run_i, m_phase == 1);
            chk(ofs_run_q == (m_phase == 2), "R6 ofs_run_q", ofs_run_q, m_phase == 2);
            chk(gain_run == (m_phase == 3), "R5 gain_run", gain_run, m_phase == 3);
            chk(cal_done == m_done[0], "R8 cal_done", cal_done, m_done);
            if (cal_busy) run_len++;
            if (prev_busy == 1 && !cal_busy) begin
                if (skip_len == 0)
                    chk(run_len == exp_total, "R3 R6 run length", run_len, exp_total);
                run_len = 0;
            end
            prev_busy = cal_busy;
        end else begin
            run_len = 0;
            prev_busy = 0;
        end
    end

    task automatic write_word(input logic [2:0] addr, input logic [15:0] w);
        @(negedge clk);
        cfg_addr = addr; cfg_word = w; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0; cfg_word = '0; cfg_addr = '0;
    endtask

    function automatic logic [15:0] start_word(input int a, input int b);
        logic [15:0] w = '0;
        w[12] = 1'b1; w[14] = a[0]; w[13] = b[0];
        return w;
    endfunction

    task automatic run_cal(input int a, input int b, input bit single, input bit q);
        single_mode = single; sel_q = q;
        exp_total = single ? (tcal(a, b) - 1024) / 2 : tcal(a, b);
        write_word(3'd0, start_word(a, b));
        chk(cal_busy == 1'b1, "R2 start", cal_busy, 1);
        while (cal_busy) @(negedge clk);
        chk(cal_done == 1'b1, "R8 done after run", cal_done, 1);
        @(negedge clk);
        chk(cal_done == 1'b0, "R8 done width", cal_done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk({cal_busy, chan_i_off, chan_q_off, ofs_run_i, ofs_run_q, gain_run, cal_done} == 7'b0,
            "R1 reset state", cal_busy, 0);
        rst = 1'b0;
        @(negedge clk);
        chk({cal_busy, chan_i_off, chan_q_off, cal_done} == 4'b0, "R1 after release", cal_busy, 0);

        // R2: wrong address, then start bit clear
        write_word(3'd3, start_word(1, 1));
        @(negedge clk);
        chk(cal_busy == 1'b0, "R2 other address", cal_busy, 0);
        write_word(3'd0, 16'h6000);
        @(negedge clk);
        chk(cal_busy == 1'b0, "R2 start bit clear", cal_busy, 0);

        // R3 / R7: 11 in dual mode, disturbed by writes during the run
        single_mode = 1'b0; sel_q = 1'b0;
        exp_total = tcal(1, 1);
        write_word(3'd0, start_word(1, 1));
        chk(cal_busy == 1'b1, "R2 start", cal_busy, 1);
        repeat (100) @(negedge clk);
        write_word(3'd0, start_word(0, 0));
        single_mode = 1'b1; sel_q = 1'b1;
        repeat (5000) @(negedge clk);
        write_word(3'd0, start_word(0, 1));
        chk(cal_busy == 1'b1, "R7 run continues", cal_busy, 1);
        single_mode = 1'b0; sel_q = 1'b0;
        while (cal_busy) @(negedge clk);
        chk(cal_done == 1'b1, "R8 done after run", cal_done, 1);
        @(negedge clk);

        run_cal(1, 0, 1'b0, 1'b0);
        run_cal(0, 1, 1'b0, 1'b0);
        run_cal(0, 0, 1'b0, 1'b0);

        // R6: single channel, each selection
        run_cal(0, 0, 1'b1, 1'b0);
        run_cal(0, 1, 1'b1, 1'b1);

        // R6 / R7: selection input changes during a single-channel run
        single_mode = 1'b1; sel_q = 1'b1;
        exp_total = (tcal(1, 0) - 1024) / 2;
        write_word(3'd0, start_word(1, 0));
        single_mode = 1'b0; sel_q = 1'b0;
        while (cal_busy) @(negedge clk);
        chk(cal_done == 1'b1, "R7 single latched", cal_done, 1);
        @(negedge clk);

        // R9: reset in the middle of a run
        single_mode = 1'b0;
        write_word(3'd0, start_word(1, 1));
        repeat (3000) @(negedge clk);
        skip_len = 1;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk({cal_busy, chan_i_off, chan_q_off, ofs_run_i, ofs_run_q, gain_run, cal_done} == 7'b0,
            "R9 reset mid-run", cal_busy, 0);
        repeat (3) @(negedge clk);
        chk(cal_busy == 1'b0, "R9 stays idle", cal_busy, 0);
        skip_len = 0;

        // restart after the reset works normally
        run_cal(0, 0, 1'b0, 1'b0);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule